// File: doc/BRIEF.md
# PWM Timer with Input Capture

A single timer channel built around one 32-bit counter. The counter advances on a tick made by two dividers in series: a prescaler that divides the system clock, and a scaler that divides the prescaler's output again. In the generating modes, the counter sweeps from zero to the programmed period and the output is active while the count is below the programmed duty value. The waveform can run for a fixed number of periods (one-shot), run until software stops it (continuous), or run as a steady reference that raises no interrupts. In capture mode, the same counter measures how long an external input stays high and how long it stays low, counted in ticks.

Software programs the channel through a plain register port. A write takes effect at the clock edge where `reg_wr` is high. A read returns data one cycle after `reg_rd`, marked by `reg_rvalid`. The port never stalls, so it has no ready signal and applies no back-pressure. A sticky status bit records period and capture events, and the interrupt output reflects that bit when the interrupt is enabled.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads back as zero, `pwm_out` is low and `irq` is low.
- R2: The counter advances once every (P+1)*(S+1) clocks. P is DIV bits 7:0 and S is DIV bits 15:8, at address 3.
- R3: Continuous mode (CTRL bits 2:1 = 1, enable is CTRL bit 0) repeats a period of PERIOD ticks (address 1). A PERIOD of 0 acts as 1. The output is active while the count is below DUTY (address 2). Every period end sets the status bit.
- R4: One-shot mode (mode 0) emits REPEAT+1 periods, where REPEAT is bits 7:0 at address 4. The status bit is set at the end of the last period, the enable bit clears itself, and the output returns to idle.
- R5: Reference mode (mode 3) produces the same waveform as continuous mode but never sets the status bit.
- R6: A PERIOD or DUTY value written while the output is running is taken up only at the next period boundary.
- R7: CTRL bit 3 inverts the output. When the channel is disabled, or in capture mode, `pwm_out` equals that bit.
- R8: In capture mode (mode 2), `cap_in` passes through a two-flop synchronizer. At each edge, the width of the level that just ended, in ticks, is stored: high widths at address 5 and low widths at address 6. The counter then restarts. A rising edge sets the status bit.
- R9: The status bit (address 7, bit 0) is cleared by writing 1 to it. Writing 0 has no effect, and a new event in the same cycle wins over the clear. `irq` is the status bit gated by CTRL bit 4.
- R10: `reg_rvalid` is high exactly one cycle after `reg_rd`, and `reg_rdata` then holds the register that was addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cap_in | input | 1 | Asynchronous signal to be measured |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request, level |

## Verification
The properties assume that software never changes the mode while the channel is enabled. They also assume that a CTRL write never lands in the same cycle that a one-shot run ends. The stimulus therefore writes CTRL to zero before each new mode and waits past the final period before touching CTRL again. The capture input is held for several clocks at each level, so that every edge passes cleanly through the synchronizer.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_CONT    = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_REF     = 2'd3
  } pwm_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_DUTY   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd3;
  localparam logic [ADDR_W-1:0] A_REPEAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAPHI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAPLO  = 3'd6;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd7;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_POL  = 3;
  localparam int CTRL_IE   = 4;
endpackage

// File: rtl/pwm_timer_sync.sv
module pwm_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_timer_clkdiv.sv
module pwm_timer_clkdiv #(
  parameter int PRE_W = 8,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [SCL_W-1:0] scl_div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [SCL_W-1:0] scl_cnt;
  logic             pre_hit;

  // first stage ends its cycle; the second stage counts those ends
  assign pre_hit = run && (pre_cnt == pre_div);
  assign tick    = pre_hit && (scl_cnt == scl_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      scl_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      scl_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      scl_cnt <= (scl_cnt == scl_div) ? '0 : scl_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  pwm_mode_e        mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [RPT_W-1:0] rpt,
  input  logic             cap_lvl,
  output logic             gen_on,
  output logic             active,
  output logic             irq_set,
  output logic             one_done,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output logic [CNT_W-1:0] cap_high,
  output logic [CNT_W-1:0] cap_low
);
  logic             cap_on;
  logic             cap_prev;
  logic             cap_rise;
  logic             cap_fall;
  logic             wrap;
  logic             last_rep;
  logic [RPT_W-1:0] rep;
  logic [CNT_W-1:0] cnt_span;

  assign gen_on   = en && (mode != MODE_CAPTURE);
  assign cap_on   = en && (mode == MODE_CAPTURE);
  assign cap_rise = cap_lvl && !cap_prev;
  assign cap_fall = !cap_lvl && cap_prev;
  // a period of zero counts as one tick
  assign wrap     = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, act_period};
  assign last_rep = (rep == rpt);
  // the edge cycle's own tick belongs to the level that just ended
  assign cnt_span = cnt + CNT_W'(tick);
  assign active   = gen_on && (cnt < act_duty);

  assign one_done = gen_on && tick && wrap && (mode == MODE_ONESHOT) && last_rep;
  assign irq_set  = one_done
                 || (gen_on && tick && wrap && (mode == MODE_CONT))
                 || (cap_on && cap_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      act_period <= '0;
      act_duty   <= '0;
      rep        <= '0;
      cap_prev   <= 1'b0;
      cap_high   <= '0;
      cap_low    <= '0;
    end else begin
      cap_prev <= cap_lvl;
      if (gen_on) begin
        if (tick) begin
          if (wrap) begin
            cnt        <= '0;
            act_period <= period;
            act_duty   <= duty;
            if (mode == MODE_ONESHOT) rep <= rep + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (cap_on) begin
        if (cap_rise) begin
          cap_low <= cnt_span;
          cnt     <= '0;
        end else if (cap_fall) begin
          cap_high <= cnt_span;
          cnt      <= '0;
        end else if (tick) begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        // idle: keep the working copies primed for the next start
        cnt        <= '0;
        act_period <= period;
        act_duty   <= duty;
        rep        <= '0;
      end
    end
  end
endmodule

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8,
  parameter int SCL_W = 8,
  parameter int RPT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_set,
  input  logic              one_done,
  input  logic [CNT_W-1:0]  cap_high,
  input  logic [CNT_W-1:0]  cap_low,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              en,
  output pwm_mode_e         mode,
  output logic              pol,
  output logic              ie,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  duty,
  output logic [PRE_W-1:0]  pre_div,
  output logic [SCL_W-1:0]  scl_div,
  output logic [RPT_W-1:0]  rpt,
  output logic              status
);
  localparam int DIV_W = PRE_W + SCL_W;

  logic [DATA_W-1:0] rd_mux;
  logic              wr_ctrl;
  logic              clr_hit;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign clr_hit = wr && (addr == A_STATUS) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      mode    <= MODE_ONESHOT;
      pol     <= 1'b0;
      ie      <= 1'b0;
      period  <= '0;
      duty    <= '0;
      pre_div <= '0;
      scl_div <= '0;
      rpt     <= '0;
    end else begin
      if (wr_ctrl) begin
        en   <= wdata[CTRL_EN];
        mode <= pwm_mode_e'(wdata[CTRL_MODE+1:CTRL_MODE]);
        pol  <= wdata[CTRL_POL];
        ie   <= wdata[CTRL_IE];
      end else if (one_done) begin
        en <= 1'b0;
      end
      if (wr && addr == A_PERIOD) period <= wdata[CNT_W-1:0];
      if (wr && addr == A_DUTY)   duty   <= wdata[CNT_W-1:0];
      if (wr && addr == A_DIV) begin
        pre_div <= wdata[PRE_W-1:0];
        scl_div <= wdata[DIV_W-1:PRE_W];
      end
      if (wr && addr == A_REPEAT) rpt <= wdata[RPT_W-1:0];
    end
  end

  // sticky event flag; a new event overrides a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 1'b0;
    else if (irq_set) status <= 1'b1;
    else if (clr_hit) status <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[CTRL_EN]                   = en;
        rd_mux[CTRL_MODE+1:CTRL_MODE]     = mode;
        rd_mux[CTRL_POL]                  = pol;
        rd_mux[CTRL_IE]                   = ie;
      end
      A_PERIOD: rd_mux = DATA_W'(period);
      A_DUTY:   rd_mux = DATA_W'(duty);
      A_DIV:    rd_mux = DATA_W'({scl_div, pre_div});
      A_REPEAT: rd_mux = DATA_W'(rpt);
      A_CAPHI:  rd_mux = DATA_W'(cap_high);
      A_CAPLO:  rd_mux = DATA_W'(cap_low);
      A_STATUS: rd_mux[0] = status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int SCL_W  = 8,
  parameter int RPT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  logic             ctrl_en, ctrl_pol, ctrl_ie, status;
  pwm_mode_e        ctrl_mode;
  logic [CNT_W-1:0] period, duty, cnt, act_period, act_duty, cap_high, cap_low;
  logic [PRE_W-1:0] pre_div;
  logic [SCL_W-1:0] scl_div;
  logic [RPT_W-1:0] rpt;
  logic             tick, gen_on, active, irq_set, one_done, cap_lvl;

  pwm_timer_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .SCL_W(SCL_W), .RPT_W(RPT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .irq_set(irq_set), .one_done(one_done),
    .cap_high(cap_high), .cap_low(cap_low), .rdata(reg_rdata),
    .rvalid(reg_rvalid), .en(ctrl_en), .mode(ctrl_mode), .pol(ctrl_pol),
    .ie(ctrl_ie), .period(period), .duty(duty), .pre_div(pre_div),
    .scl_div(scl_div), .rpt(rpt), .status(status)
  );

  pwm_timer_clkdiv #(.PRE_W(PRE_W), .SCL_W(SCL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .pre_div(pre_div),
    .scl_div(scl_div), .tick(tick)
  );

  pwm_timer_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_in), .q(cap_lvl)
  );

  pwm_timer_core #(.CNT_W(CNT_W), .RPT_W(RPT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mode(ctrl_mode), .tick(tick),
    .period(period), .duty(duty), .rpt(rpt), .cap_lvl(cap_lvl),
    .gen_on(gen_on), .active(active), .irq_set(irq_set), .one_done(one_done),
    .cnt(cnt), .act_period(act_period), .act_duty(act_duty),
    .cap_high(cap_high), .cap_low(cap_low)
  );

  assign pwm_out = ctrl_pol ^ active;
  assign irq     = status && ctrl_ie;
endmodule

// File: rtl/pwm_timer_sva.sv
module pwm_timer_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             reg_rvalid,
  input logic             pwm_out,
  input logic             ctrl_en,
  input logic             ctrl_pol,
  input logic             gen_on,
  input logic             tick,
  input logic             status,
  input logic             irq_set,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty
);
  assert_rvalid_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  assert_status_rise_has_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(irq_set));

  assert_count_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_on && act_period != '0) |-> (cnt < act_period));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (pwm_out == ctrl_pol));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_on && !tick) |=> ($stable(act_period) && $stable(act_duty)));

  assert_count_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_on && !tick) |=> $stable(cnt));
endmodule

bind pwm_timer pwm_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .pwm_out(pwm_out), .ctrl_en(ctrl_en), .ctrl_pol(ctrl_pol), .gen_on(gen_on),
  .tick(tick), .status(status), .irq_set(irq_set), .cnt(cnt),
  .act_period(act_period), .act_duty(act_duty)
);

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int    n_checks = 0, n_fail = 0;
  bit    done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
  );

  // behavioural reference: register image plus timing state, advanced per clock
  int     m_en, m_mode, m_pol, m_ie, m_status, m_rvalid;
  longint m_period, m_duty, m_pre, m_scl, m_rpt, m_caph, m_capl, m_rdata;
  longint cnt, a_per, a_duty, rep, pre_c, scl_c;
  int     s1, s2, s3;

  function automatic longint model_read(input int a);
    case (a)
      0: return m_en | (m_mode << 1) | (m_pol << 3) | (m_ie << 4);
      1: return m_period;
      2: return m_duty;
      3: return m_pre | (m_scl << 8);
      4: return m_rpt;
      5: return m_caph;
      6: return m_capl;
      default: return m_status;
    endcase
  endfunction

  always @(posedge clk) begin
    int run, gen, capm, tk, setb, clr;
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_pol = 0; m_ie = 0; m_status = 0; m_rvalid = 0;
      m_period = 0; m_duty = 0; m_pre = 0; m_scl = 0; m_rpt = 0;
      m_caph = 0; m_capl = 0; m_rdata = 0;
      cnt = 0; a_per = 0; a_duty = 0; rep = 0; pre_c = 0; scl_c = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      m_rvalid = reg_rd;
      if (reg_rd) m_rdata = model_read(reg_addr);
      run  = m_en;
      gen  = m_en && m_mode != 2;
      capm = m_en && m_mode == 2;
      tk   = run && pre_c == m_pre && scl_c == m_scl;
      setb = 0; clr = 0;
      if (gen) begin
        if (tk) begin
          if (cnt + 1 >= a_per) begin
            cnt = 0; a_per = m_period; a_duty = m_duty;
            if (m_mode == 0) begin
              if (rep == m_rpt) begin setb = 1; clr = 1; end
              rep = rep + 1;
            end else if (m_mode == 1) setb = 1;
          end else cnt = cnt + 1;
        end
      end else if (capm) begin
        if (s2 && !s3) begin m_capl = cnt + tk; cnt = 0; setb = 1; end
        else if (!s2 && s3) begin m_caph = cnt + tk; cnt = 0; end
        else if (tk) cnt = cnt + 1;
      end else begin
        cnt = 0; a_per = m_period; a_duty = m_duty; rep = 0;
      end
      if (!run) begin pre_c = 0; scl_c = 0; end
      else if (pre_c == m_pre) begin
        pre_c = 0;
        scl_c = (scl_c == m_scl) ? 0 : scl_c + 1;
      end else pre_c = pre_c + 1;
      s3 = s2; s2 = s1; s1 = cap_in;
      if (reg_wr && reg_addr == 7 && reg_wdata[0]) m_status = 0;
      if (setb) m_status = 1;
      if (clr) m_en = 0;
      if (reg_wr) begin
        case (reg_addr)
          0: begin
            m_en = reg_wdata[0]; m_mode = int'(reg_wdata[2:1]);
            m_pol = reg_wdata[3]; m_ie = reg_wdata[4];
          end
          1: m_period = reg_wdata;
          2: m_duty = reg_wdata;
          3: begin m_pre = reg_wdata[7:0]; m_scl = reg_wdata[15:8]; end
          4: m_rpt = reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every clock, compare the outputs against the reference, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_out;
      exp_out = m_pol ^ ((m_en && m_mode != 2 && cnt < a_duty) ? 1 : 0);
      check(pwm_out == exp_out[0], {phase, " pwm_out"}, pwm_out, exp_out);
      check(irq == (m_status && m_ie), {phase, " irq"}, irq, m_status && m_ie);
      check(reg_rvalid == m_rvalid[0], "R10 rvalid", reg_rvalid, m_rvalid);
      if (reg_rvalid)
        check(reg_rdata == m_rdata[31:0], {phase, " rdata"}, reg_rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[2:0]; reg_wdata = d[31:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(input int a, input longint exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a[2:0];
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rvalid == 1'b1, "R10 read strobe", reg_rvalid, 1);
    check(reg_rdata == exp[31:0], tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap_level(input bit v, input int n);
    @(negedge clk);
    cap_in = v;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 reset pwm_out", pwm_out, 0);
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_expect(a, 0, "R1 reset register");

    // continuous: period 5, duty 2, interrupts enabled
    phase = "R3";
    wr(1, 5); wr(2, 2); wr(0, 19);
    idle(22);
    rd_expect(7, 1, "R3 status after period end");
    wr(0, 0);
    check(irq == 1'b0, "R9 irq gated when disabled", irq, 0);
    phase = "R9";
    wr(7, 0); rd_expect(7, 1, "R9 write 0 leaves status");
    wr(7, 1); rd_expect(7, 0, "R9 write 1 clears status");

    // shadow update mid-period
    phase = "R6";
    wr(0, 19); idle(3);
    wr(1, 9); wr(2, 6);
    idle(30);
    wr(0, 0);

    // inverted polarity
    phase = "R7";
    wr(0, 8); idle(1);
    check(pwm_out == 1'b1, "R7 idle level inverted", pwm_out, 1);
    wr(0, 27); idle(20);
    wr(0, 0); wr(7, 1);

    // two-stage divider: P=1, S=2
    phase = "R2";
    wr(3, 32'h0201); wr(1, 3); wr(2, 1); wr(0, 19);
    idle(60);
    wr(0, 0); wr(3, 0); wr(7, 1);

    // one-shot: three periods of 4
    phase = "R4";
    wr(1, 4); wr(2, 2); wr(4, 2); wr(0, 17);
    idle(30);
    rd_expect(0, 16, "R4 enable self-cleared");
    rd_expect(7, 1, "R4 status at last period");
    check(pwm_out == 1'b0, "R4 output idle after run", pwm_out, 0);
    wr(7, 1);

    // reference: runs without events
    phase = "R5";
    wr(1, 3); wr(2, 2); wr(0, 23);
    idle(20);
    rd_expect(7, 0, "R5 no status in reference mode");
    wr(0, 0);

    // zero period behaves as one
    phase = "R3";
    wr(1, 0); wr(2, 1); wr(0, 3);
    idle(8);
    check(pwm_out == 1'b1, "R3 zero period stays active", pwm_out, 1);
    wr(0, 0);

    // capture: high 7 clocks, low 4 clocks
    phase = "R8";
    wr(0, 21); idle(5);
    cap_level(1'b1, 7);
    cap_level(1'b0, 4);
    cap_level(1'b1, 7);
    cap_level(1'b0, 10);
    rd_expect(5, 7, "R8 high width");
    rd_expect(6, 4, "R8 low width");
    rd_expect(7, 1, "R8 status on rising edge");
    wr(0, 0);
    rd_expect(1, 0, "R10 period readback");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule